// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is one DMA channel. When started, it either reads a four-word descriptor from memory or takes its source, target and command words straight from its configuration inputs. It then copies data from the source address to the target address in bursts. Each burst is read completely into a local buffer and then written out completely. A single word-wide request port reaches memory, and only one request is outstanding at a time.

The command word sets the element width, the burst size, the remaining byte length, whether each address increments, and whether a peripheral request line gates the transfer. When a transfer finishes, the channel either stops or follows the next-descriptor pointer. The compare flag can redirect the fetch to an alternate descriptor 32 bytes further on. A peripheral that drops its request in the middle of a flow-controlled transfer ends that transfer early. The channel then stops or jumps to the next descriptor, as its mode selects.

The status outputs show the running and stopped state, the start, end and end-of-receive flags, and the live next, source, target and command registers. A control/status block reads these outputs.

Top module: `dmac_chain_engine`

## Requirements
- R1: After reset, run_o=0, stopped_o=1, all three flags are 0 and mem_valid_o=0.
- R2: A descriptor fetch issues four word reads (mem_size_o=2) at base, base+4, base+8 and base+12. The words are next, source, target and command, in that order. The base is the next pointer with bits [3:0] cleared. Command bit 29 clears source bits [1:0] at fetch time, and command bit 28 does the same for the target.
- R3: The fetch base is 32 higher when bit 1 of the next pointer is set and cmp_flag_i is high at the moment the fetch begins.
- R4: Command bits [17:16] set the burst size to 4<<code bytes. Bits [15:14] set the element width: code 1 is 1 byte, code 2 is 2 bytes, code 3 is 4 bytes, and mem_size_o is 0, 1 or 2 to match. Bits [12:0] hold the remaining length. The last burst is cut down to the remaining length. Each burst performs all of its reads before any of its writes.
- R5: After each element, the source address advances by the element width when command bit 31 is set, and the target address does the same when bit 30 is set. An address whose bit is clear stays unchanged.
- R6: When the length reaches 0, end_flag_o sets if command bit 21 is 1. The channel then stops if no-fetch mode is active, if bit 0 of the next pointer is set, or if the end-of-receive stop mode is enabled. Otherwise it fetches the next descriptor.
- R7: start_flag_o sets when a fetched command has bit 22 set. A start request clears all three flags.
- R8: A flow-controlled transfer (command bit 28 or 29 set) makes no memory request while dreq_i is low.
- R9: Suppose a flow-controlled burst ends while dreq_i is low. Then eor_flag_o sets. With eor_stop_en the channel stops and leaves the remaining length in cmd_o[12:0]. With eor_jump_en, and descriptor fetch enabled, it fetches the next descriptor.
- R10: A request is held with a stable address and direction until mem_ready_i is high. No request is made while run_o is 0.
- R11: With nofetch_i set at start, the channel copies using prog_src_i, prog_tgt_i and prog_cmd_i without reading any descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while stopped |
| nofetch_i | input | 1 | Run from the programmed registers, with no fetch |
| eor_stop_en_i | input | 1 | Stop at end of receive and at completion |
| eor_jump_en_i | input | 1 | Fetch the next descriptor at end of receive |
| cmp_flag_i | input | 1 | Compare status, selects the alternate descriptor |
| desc_ptr_i | input | 32 | First next-descriptor pointer |
| prog_src_i | input | 32 | Programmed source for no-fetch mode |
| prog_tgt_i | input | 32 | Programmed target for no-fetch mode |
| prog_cmd_i | input | 32 | Programmed command for no-fetch mode |
| dreq_i | input | 1 | Peripheral request line |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 2 | 0 = byte, 1 = half-word, 2 = word |
| mem_wdata_o | output | 32 | Write data, right-justified |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 32 | Read data, right-justified, valid with ready |
| run_o | output | 1 | Channel running |
| stopped_o | output | 1 | Channel stopped |
| start_flag_o | output | 1 | Start flag |
| end_flag_o | output | 1 | End flag |
| eor_flag_o | output | 1 | End-of-receive flag |
| next_o | output | 32 | Next-descriptor register |
| src_o | output | 32 | Source address register |
| tgt_o | output | 32 | Target address register |
| cmd_o | output | 32 | Command register with the live length |

## Verification
A wrong decode of the width or burst code shows up in the first burst. The read/write pattern on the memory port changes, and so do the final source and target values. A wrong fetch base or branch offset moves the first read address. A wrong flow-control decision shows up as requests made while dreq_i is low, or as a remaining length in cmd_o that is not the one expected. Each of these errors appears within one burst of its cause. The chaining and stop decisions are visible in next_o and in the data that lands in the target region.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR, S_POST, S_FIN
  } dmac_state_e;

  localparam int B_INC_SRC  = 31;
  localparam int B_INC_TGT  = 30;
  localparam int B_FLOW_SRC = 29;
  localparam int B_FLOW_TGT = 28;
  localparam int B_START_IE = 22;
  localparam int B_END_IE   = 21;

  // log2 of element width in bytes from command width code
  function automatic logic [1:0] width_lg(input logic [1:0] code);
    case (code)
      2'd3:    return 2'd2;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [5:0] burst_bytes(input logic [1:0] code);
    return 6'd4 << code;
  endfunction

  // descriptor fetch base: 16-byte aligned, +32 on branch with compare set
  function automatic logic [31:0] desc_base(input logic [31:0] nxt, input logic cmp);
    return {nxt[31:4], 4'b0000} + ((nxt[1] && cmp) ? 32'd32 : 32'd0);
  endfunction

  function automatic logic [31:0] addr_step(input logic [1:0] code, input logic inc);
    return inc ? (32'd1 << width_lg(code)) : 32'd0;
  endfunction
endpackage

// File: rtl/dmac_xfer_calc.sv
module dmac_xfer_calc
  import dmac_pkg::*;
#(
  parameter int LEN_W = 13,
  parameter int IDX_W = 6
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       burst_code_i,
  input  logic [1:0]       width_code_i,
  input  logic             inc_src_i,
  input  logic             inc_tgt_i,
  output logic [LEN_W-1:0] chunk_o,
  output logic [IDX_W-1:0] elems_o,
  output logic [31:0]      src_step_o,
  output logic [31:0]      tgt_step_o
);
  logic [LEN_W-1:0] bb, wb, rounded;

  always_comb begin
    bb         = LEN_W'(burst_bytes(burst_code_i));
    chunk_o    = (len_i < bb) ? len_i : bb;
    wb         = LEN_W'(1) << width_lg(width_code_i);
    rounded    = (chunk_o + wb - LEN_W'(1)) >> width_lg(width_code_i);
    elems_o    = IDX_W'(rounded);
    src_step_o = addr_step(width_code_i, inc_src_i);
    tgt_step_o = addr_step(width_code_i, inc_tgt_i);
  end
endmodule

// File: rtl/dmac_elem_buf.sv
module dmac_elem_buf #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[widx_i[AW-1:0]] <= wdata_i;
  end

  assign rdata_o = store[ridx_i[AW-1:0]];

  AST_BUF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (widx_i < IDX_W'(DEPTH))); // R4
endmodule

// File: rtl/dmac_chain_engine.sv
module dmac_chain_engine
  import dmac_pkg::*;
#(
  parameter int LEN_W     = 13,
  parameter int MAX_BURST = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        nofetch_i,
  input  logic        eor_stop_en_i,
  input  logic        eor_jump_en_i,
  input  logic        cmp_flag_i,
  input  logic [31:0] desc_ptr_i,
  input  logic [31:0] prog_src_i,
  input  logic [31:0] prog_tgt_i,
  input  logic [31:0] prog_cmd_i,
  input  logic        dreq_i,
  output logic        mem_valid_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [1:0]  mem_size_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ready_i,
  input  logic [31:0] mem_rdata_i,
  output logic        run_o,
  output logic        stopped_o,
  output logic        start_flag_o,
  output logic        end_flag_o,
  output logic        eor_flag_o,
  output logic [31:0] next_o,
  output logic [31:0] src_o,
  output logic [31:0] tgt_o,
  output logic [31:0] cmd_o
);
  localparam int IDX_W = $clog2(MAX_BURST + 1);

  dmac_state_e      st;
  logic [1:0]       fidx;
  logic [IDX_W-1:0] eidx;
  logic [31:0]      nxt, src, tgt, cmd, fbase;
  logic             m_nofetch, m_eor_stop, m_eor_jump;

  logic [LEN_W-1:0] cmd_len, chunk;
  logic [IDX_W-1:0] elems;
  logic [31:0]      src_step, tgt_step, buf_rdata;

  // named internal events
  logic flow_mode, xfer_hs, last_elem, burst_end, flow_blocked;

  assign cmd_len      = cmd[LEN_W-1:0];
  assign flow_mode    = cmd[B_FLOW_SRC] | cmd[B_FLOW_TGT];
  assign xfer_hs      = mem_valid_o && mem_ready_i;
  assign last_elem    = (eidx == elems - 1'b1);
  assign burst_end    = (st == S_WR) && xfer_hs && last_elem;
  assign flow_blocked = flow_mode && !dreq_i;

  dmac_xfer_calc #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_calc (
    .len_i(cmd_len), .burst_code_i(cmd[17:16]), .width_code_i(cmd[15:14]),
    .inc_src_i(cmd[B_INC_SRC]), .inc_tgt_i(cmd[B_INC_TGT]),
    .chunk_o(chunk), .elems_o(elems), .src_step_o(src_step), .tgt_step_o(tgt_step)
  );

  dmac_elem_buf #(.DEPTH(MAX_BURST), .DATA_W(32), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .we_i((st == S_RD) && mem_ready_i), .widx_i(eidx), .wdata_i(mem_rdata_i),
    .ridx_i(eidx), .rdata_o(buf_rdata)
  );

  always_comb begin
    mem_valid_o = (st == S_FETCH) || (st == S_RD) || (st == S_WR);
    mem_we_o    = (st == S_WR);
    mem_wdata_o = buf_rdata;
    mem_size_o  = width_lg(cmd[15:14]);
    case (st)
      S_FETCH: begin
        mem_addr_o = fbase + {28'd0, fidx, 2'b00};
        mem_size_o = 2'd2;
      end
      S_WR:    mem_addr_o = tgt;
      default: mem_addr_o = src;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; fidx <= '0; eidx <= '0;
      nxt <= '0; src <= '0; tgt <= '0; cmd <= '0; fbase <= '0;
      m_nofetch <= 1'b0; m_eor_stop <= 1'b0; m_eor_jump <= 1'b0;
      run_o <= 1'b0; stopped_o <= 1'b1;
      start_flag_o <= 1'b0; end_flag_o <= 1'b0; eor_flag_o <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          run_o <= 1'b1; stopped_o <= 1'b0;
          start_flag_o <= 1'b0; end_flag_o <= 1'b0; eor_flag_o <= 1'b0;
          m_nofetch <= nofetch_i; m_eor_stop <= eor_stop_en_i; m_eor_jump <= eor_jump_en_i;
          if (nofetch_i) begin
            src <= prog_src_i; tgt <= prog_tgt_i; cmd <= prog_cmd_i;
            st <= S_CHECK;
          end else begin
            nxt <= desc_ptr_i; fbase <= desc_base(desc_ptr_i, cmp_flag_i);
            fidx <= '0; st <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ready_i) begin
          fidx <= fidx + 2'd1;
          case (fidx)
            2'd0: nxt <= mem_rdata_i;
            2'd1: src <= mem_rdata_i;
            2'd2: tgt <= mem_rdata_i;
            default: begin
              cmd <= mem_rdata_i;
              if (mem_rdata_i[B_FLOW_SRC]) src <= {src[31:2], 2'b00};
              if (mem_rdata_i[B_FLOW_TGT]) tgt <= {tgt[31:2], 2'b00};
              if (mem_rdata_i[B_START_IE]) start_flag_o <= 1'b1;
              st <= S_CHECK;
            end
          endcase
        end
        S_CHECK: begin
          if (cmd_len == '0) st <= S_FIN;
          else if (!flow_blocked) begin
            eidx <= '0; st <= S_RD;
          end
        end
        S_RD: if (mem_ready_i) begin
          src <= src + src_step;
          if (last_elem) begin
            eidx <= '0; st <= S_WR;
          end else eidx <= eidx + 1'b1;
        end
        S_WR: if (mem_ready_i) begin
          tgt <= tgt + tgt_step;
          if (last_elem) begin
            cmd[LEN_W-1:0] <= cmd_len - chunk;
            st <= S_POST;
          end else eidx <= eidx + 1'b1;
        end
        S_POST: begin
          if (flow_blocked) begin
            eor_flag_o <= 1'b1;
            if (m_eor_stop) begin
              run_o <= 1'b0; stopped_o <= 1'b1; st <= S_IDLE;
            end else if (m_eor_jump && !m_nofetch) begin
              fbase <= desc_base(nxt, cmp_flag_i); fidx <= '0; st <= S_FETCH;
            end else st <= S_CHECK;
          end else st <= S_CHECK;
        end
        S_FIN: begin
          if (cmd[B_END_IE]) end_flag_o <= 1'b1;
          if (m_nofetch || nxt[0] || m_eor_stop) begin
            run_o <= 1'b0; stopped_o <= 1'b1; st <= S_IDLE;
          end else begin
            fbase <= desc_base(nxt, cmp_flag_i); fidx <= '0; st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign next_o = nxt;
  assign src_o  = src;
  assign tgt_o  = tgt;
  assign cmd_o  = cmd;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> !mem_valid_o); // R10
  AST_RUN_XOR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    run_o ^ stopped_o); // R6
  AST_FLOW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_CHECK) && flow_blocked) |=> !mem_valid_o); // R8
  AST_FETCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH) |-> (mem_size_o == 2'd2 && mem_addr_o[1:0] == 2'b00 && !mem_we_o)); // R2
  AST_LEN_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |=> (cmd_len < $past(cmd_len))); // R4
  AST_START_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_flag_o) |-> ($past(st) == S_FETCH)); // R7
endmodule

// File: tb/dmac_chain_engine_bench.sv
`timescale 1ns/1ps
module dmac_chain_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start_i = 0, nofetch_i = 0, eor_stop_en_i = 0, eor_jump_en_i = 0, cmp_flag_i = 0, dreq_i = 0;
  logic [31:0] desc_ptr_i = 0, prog_src_i = 0, prog_tgt_i = 0, prog_cmd_i = 0;
  logic mem_valid_o, mem_we_o, mem_ready_i;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [1:0] mem_size_o;
  logic run_o, stopped_o, start_flag_o, end_flag_o, eor_flag_o;
  logic [31:0] next_o, src_o, tgt_o, cmd_o;

  dmac_chain_engine u_dmac_chain_engine (.*);

  // memory model
  logic [7:0] mem [0:1023];
  logic [7:0] lf;
  logic init_req = 0, poke_en = 0, log_clr = 0;
  logic [9:0] poke_a = 0;
  logic [31:0] poke_d = 0;
  logic [31:0] rd_log [0:63];
  int rd_cnt, wr_cnt, bursts;
  logic last_rd;
  logic [9:0] ma;
  assign ma = mem_addr_o[9:0];
  assign mem_ready_i = lf[0] | lf[2];

  always_comb begin
    case (mem_size_o)
      2'd0:    mem_rdata_i = {24'd0, mem[ma]};
      2'd1:    mem_rdata_i = {16'd0, mem[ma + 10'd1], mem[ma]};
      default: mem_rdata_i = {mem[ma + 10'd3], mem[ma + 10'd2], mem[ma + 10'd1], mem[ma]};
    endcase
  end

  function automatic logic [7:0] pat(input int i);
    return (i < 512) ? 8'(i * 3 + 1) : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) lf <= 8'hA5;
    else lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (init_req) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else if (poke_en) begin
      mem[poke_a] <= poke_d[7:0]; mem[poke_a + 10'd1] <= poke_d[15:8];
      mem[poke_a + 10'd2] <= poke_d[23:16]; mem[poke_a + 10'd3] <= poke_d[31:24];
    end else if (mem_valid_o && mem_ready_i && mem_we_o) begin
      mem[ma] <= mem_wdata_o[7:0];
      if (mem_size_o != 2'd0) mem[ma + 10'd1] <= mem_wdata_o[15:8];
      if (mem_size_o == 2'd2) begin
        mem[ma + 10'd2] <= mem_wdata_o[23:16]; mem[ma + 10'd3] <= mem_wdata_o[31:24];
      end
    end
    if (log_clr) begin
      rd_cnt <= 0; wr_cnt <= 0; bursts <= 0; last_rd <= 1'b0;
    end else if (mem_valid_o && mem_ready_i) begin
      if (!mem_we_o) begin
        if (rd_cnt < 64) rd_log[rd_cnt] <= mem_addr_o;
        rd_cnt <= rd_cnt + 1; last_rd <= 1'b1;
      end else begin
        wr_cnt <= wr_cnt + 1;
        if (last_rd) bursts <= bursts + 1;
        last_rd <= 1'b0;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); poke_en = 1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic put_desc(input logic [9:0] a, input logic [31:0] n, s, t, c);
    poke(a, n); poke(a + 10'd4, s); poke(a + 10'd8, t); poke(a + 10'd12, c);
  endtask

  task automatic fresh_mem;
    @(negedge clk); init_req = 1;
    @(negedge clk); init_req = 0;
  endtask

  task automatic launch(input logic nf, es, ej, cmp, input logic [31:0] ptr, ps, pt, pc);
    @(negedge clk); log_clr = 1;
    @(negedge clk); log_clr = 0;
    nofetch_i = nf; eor_stop_en_i = es; eor_jump_en_i = ej; cmp_flag_i = cmp;
    desc_ptr_i = ptr; prog_src_i = ps; prog_tgt_i = pt; prog_cmd_i = pc; start_i = 1;
    @(negedge clk); start_i = 0;
  endtask

  task automatic wait_stop(input string tag);
    int n = 0;
    while (!stopped_o && n < 5000) begin @(negedge clk); n++; end
    if (!stopped_o) begin
      checks++; fails++;
      $display("FAIL %s: actual running expected stopped", tag);
    end
  endtask

  task automatic chk_copy(input string tag, input int s, input int t, input int n);
    for (int k = 0; k < n; k++) chk(tag, {24'd0, mem[t + k]}, {24'd0, pat(s + k)});
  endtask

  localparam logic [31:0] INC2 = 32'hC000_0000;

  task automatic t_reset;
    chk("R1 run", {31'd0, run_o}, 0);
    chk("R1 stopped", {31'd0, stopped_o}, 1);
    chk("R1 flags", {29'd0, start_flag_o, end_flag_o, eor_flag_o}, 0);
    chk("R1 valid", {31'd0, mem_valid_o}, 0);
  endtask

  task automatic t_nofetch_words;
    launch(1, 0, 0, 0, 0, 32'h40, 32'h200, INC2 | (1 << 16) | (3 << 14) | 20);
    wait_stop("R11 finish");
    chk_copy("R11 data", 'h40, 'h200, 20);
    chk("R4 reads", rd_cnt, 5);
    chk("R4 bursts", bursts, 3);
    chk("R5 src", src_o, 32'h54);
    chk("R5 tgt", tgt_o, 32'h214);
    chk("R4 len", {19'd0, cmd_o[12:0]}, 0);
    chk("R7 no start flag", {31'd0, start_flag_o}, 0);
    chk("R6 no end flag", {31'd0, end_flag_o}, 0);
  endtask

  task automatic t_bytes_fixed_tgt;
    launch(1, 0, 0, 0, 0, 32'h80, 32'h220, 32'h8000_0000 | (1 << 14) | 6);
    wait_stop("R5 finish");
    chk("R5 fixed tgt data", {24'd0, mem['h220]}, {24'd0, pat('h85)});
    chk("R5 next byte untouched", {24'd0, mem['h221]}, 0);
    chk("R5 src", src_o, 32'h86);
    chk("R5 tgt", tgt_o, 32'h220);
    chk("R4 short burst", bursts, 2);
    chk("R4 writes", wr_cnt, 6);
  endtask

  task automatic t_chain;
    put_desc(10'h300, 32'h340, 32'hA0, 32'h240, INC2 | (1 << 22) | (1 << 21) | (2 << 16) | (3 << 14) | 8);
    put_desc(10'h340, 32'h1, 32'hC0, 32'h250, INC2 | (1 << 21) | (2 << 14) | 4);
    launch(0, 0, 0, 0, 32'h300, 0, 0, 0);
    wait_stop("R6 chain finish");
    chk("R2 fetch0", rd_log[0], 32'h300);
    chk("R2 fetch1", rd_log[1], 32'h304);
    chk("R2 fetch3", rd_log[3], 32'h30C);
    chk("R6 chained fetch", rd_log[6], 32'h340);
    chk_copy("R6 first copy", 'hA0, 'h240, 8);
    chk_copy("R6 second copy", 'hC0, 'h250, 4);
    chk("R7 start flag", {31'd0, start_flag_o}, 1);
    chk("R6 end flag", {31'd0, end_flag_o}, 1);
    chk("R6 next", next_o, 32'h1);
    chk("R6 run cleared", {31'd0, run_o}, 0);
  endtask

  task automatic t_branch;
    put_desc(10'h380, 32'h1, 32'hD0, 32'h270, INC2 | (3 << 14) | (1 << 16) | 4);
    put_desc(10'h3A0, 32'h1, 32'hE0, 32'h260, INC2 | (3 << 14) | (1 << 16) | 4);
    launch(0, 0, 0, 1, 32'h382, 0, 0, 0);
    wait_stop("R3 finish");
    chk("R3 branch fetch", rd_log[0], 32'h3A0);
    chk_copy("R3 alternate copy", 'hE0, 'h260, 4);
    chk("R3 primary untouched", {24'd0, mem['h270]}, 0);
    launch(0, 0, 0, 0, 32'h382, 0, 0, 0);
    wait_stop("R3 finish2");
    chk("R3 no branch fetch", rd_log[0], 32'h380);
    chk_copy("R3 primary copy", 'hD0, 'h270, 4);
  endtask

  task automatic t_flow_stop;
    int q = 0;
    put_desc(10'h3C0, 32'h1, 32'h103, 32'h280, INC2 | (1 << 29) | (3 << 14) | (1 << 16) | 16);
    dreq_i = 0;
    launch(0, 1, 0, 0, 32'h3C0, 0, 0, 0);
    repeat (30) begin @(negedge clk); if (mem_valid_o && rd_cnt >= 4) q++; end
    chk("R8 no access while dreq low", q, 0);
    chk("R8 only fetch reads", rd_cnt, 4);
    chk("R8 still running", {31'd0, run_o}, 1);
    dreq_i = 1;
    while (wr_cnt < 1) @(negedge clk);
    dreq_i = 0;
    wait_stop("R9 stop finish");
    chk("R9 eor flag", {31'd0, eor_flag_o}, 1);
    chk("R9 remaining", {19'd0, cmd_o[12:0]}, 8);
    chk("R2 masked src advance", src_o, 32'h108);
    chk_copy("R9 partial copy", 'h100, 'h280, 8);
    chk("R9 no more", {24'd0, mem['h288]}, 0);
    chk("R9 no end flag", {31'd0, end_flag_o}, 0);
  endtask

  task automatic t_flow_jump;
    put_desc(10'h3E0, 32'h3F0, 32'h110, 32'h2A0, INC2 | (1 << 28) | (3 << 14) | (1 << 16) | 16);
    put_desc(10'h3F0, 32'h1, 32'h1C0, 32'h2C0, INC2 | (1 << 21) | (3 << 14) | 4);
    dreq_i = 1;
    launch(0, 0, 1, 0, 32'h3E0, 0, 0, 0);
    while (wr_cnt < 1) @(negedge clk);
    dreq_i = 0;
    wait_stop("R9 jump finish");
    chk("R9 jump eor flag", {31'd0, eor_flag_o}, 1);
    chk_copy("R9 jump partial", 'h110, 'h2A0, 8);
    chk("R9 jump cut", {24'd0, mem['h2A8]}, 0);
    chk_copy("R9 jumped copy", 'h1C0, 'h2C0, 4);
    chk("R9 jumped end flag", {31'd0, end_flag_o}, 1);
    chk("R9 jumped next", next_o, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    fresh_mem;
    t_nofetch_words;
    t_bytes_fixed_tgt;
    t_chain;
    t_branch;
    t_flow_stop;
    t_flow_jump;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule